// File: doc/BRIEF.md
# Bus Grant Daisy-Chain Requester Node

This block sits on each module of a shared parallel bus that arbitrates with four request levels and a grant daisy chain. When the local master wants the bus, the node pulls down the request line of its configured level. That line is wired-AND across modules, so it behaves as an open-drain output. The node then watches the grant-in line of the same level. A grant that reaches a node with no request of its own is copied to that node's grant-out line, so it travels on to the next module. A grant that reaches a requesting node stops there. That node keeps its grant-out negated, drops its request and tells the local master that it owns the bus.

The master ends its tenure with a one-cycle done pulse. The node then stays in a draining phase, with grant-out on its level still blocked, until it sees grant-in negated. Only after that can it pass grants again or raise a new request. The grant lines on the three levels the node does not use pass through with one register stage. The central arbiter is outside this block.

Top module: `bgchain_node`

## Requirements
- R1: While rst_n is low, every bit of bus_req_n and bgout_n is 1 and bus_own is 0.
- R2: All request and grant lines are active low, and bit index i of each vector is level i. The node drives a 0 only on bus_req_n[lvl_sel], and never on more than one bit.
- R3: When the node is not holding a grant, bgout_n[i] equals bgin_n[i] as sampled at the previous rising edge. This holds on every level that is not lvl_sel, and on lvl_sel while the node is idle.
- R4: In idle, with mst_req high and bgin_n[lvl_sel] high at a rising edge, bus_req_n[lvl_sel] goes to 0 after that edge. While bgin_n[lvl_sel] is low, no request is raised.
- R5: From the edge that starts a request until the node returns to idle, bgout_n[lvl_sel] is 1 regardless of bgin_n[lvl_sel].
- R6: A requesting node that samples bgin_n[lvl_sel] low sets bus_own to 1 after that edge and releases bus_req_n in the same cycle. In a chain, at most one node owns the bus at any time.
- R7: mst_done high at a rising edge while bus_own is 1 clears bus_own after that edge.
- R8: After ownership ends, the node raises no request and keeps bgout_n[lvl_sel] at 1 until it samples bgin_n[lvl_sel] high. A new request can appear no earlier than the second edge after that.
- R9: mst_done has no effect on any output unless bus_own is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lvl_sel | input | 2 | Static request level of this node (0 to 3) |
| mst_req | input | 1 | Local master wants the bus (level) |
| mst_done | input | 1 | Local master ends its tenure (one-cycle pulse) |
| bus_own | output | 1 | Node holds the bus for the local master |
| bgin_n | input | 4 | Grant-in per level from the upstream module, active low |
| bgout_n | output | 4 | Grant-out per level to the downstream module, active low |
| bus_req_n | output | 4 | Request pull-down per level, active low, wired-AND on the bus |

## Verification
The critical coincidence is a grant on the node's own level that is passing through the idle node in the same cycle the local master raises its request. If the node simply started requesting, it would cut that grant in half while a downstream module is still using it. The bench provokes this directly: it holds bgin_n on the node's level low while raising mst_req. It then expects no request and an unbroken copy on grant-out until grant-in is negated, and a request one edge later. In the randomized run, four chained nodes with a bench arbiter meet the same overlap many times. That run is judged by single ownership on every cycle, by ownership only for nodes that asked for the bus, and by every node eventually being served.

// File: rtl/bgn_pkg.sv
package bgn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_OWN   = 2'd2,
    ST_DRAIN = 2'd3
  } bgn_state_e;
endpackage

// File: rtl/bgn_lane.sv
module bgn_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic gin_n,
  input  logic blk_i,
  output logic gout_n
);
  logic gout_q;
  logic gout_d;

  always_comb begin
    gout_d = gin_n | blk_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gout_q <= 1'b1;
    else        gout_q <= gout_d;
  end

  assign gout_n = gout_q;

  // R3
  pass_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(blk_i)) |-> (gout_n == $past(gin_n)));

  // R5
  hold_negated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(blk_i)) |-> gout_n);
endmodule

// File: rtl/bgn_fsm.sv
module bgn_fsm
  import bgn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mst_req,
  input  logic mst_done,
  input  logic gin_sel_n,
  output logic req_act,
  output logic own,
  output logic blk
);
  bgn_state_e st_q;
  bgn_state_e st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (mst_req && gin_sel_n) st_d = ST_REQ;
      ST_REQ:   if (!gin_sel_n)           st_d = ST_OWN;
      ST_OWN:   if (mst_done)             st_d = ST_DRAIN;
      ST_DRAIN: if (gin_sel_n)            st_d = ST_IDLE;
      default:                            st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign req_act = (st_q == ST_REQ);
  assign own     = (st_q == ST_OWN);
  assign blk     = (st_q != ST_IDLE);

  // R6
  grant_to_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own) |-> ($past(req_act) && !$past(gin_sel_n)));

  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own && mst_done) |=> !own);

  // R8
  req_start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_act) |-> ($past(gin_sel_n) && $past(mst_req)));

  // R9
  done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!own && mst_done && !mst_req) |=> !req_act || $past(req_act));
endmodule

// File: rtl/bgchain_node.sv
module bgchain_node #(
  parameter int NUM_LVL = 4,
  localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   lvl_sel,
  input  logic               mst_req,
  input  logic               mst_done,
  output logic               bus_own,
  input  logic [NUM_LVL-1:0] bgin_n,
  output logic [NUM_LVL-1:0] bgout_n,
  output logic [NUM_LVL-1:0] bus_req_n
);
  logic gin_sel_n;
  logic req_act;
  logic blk;

  assign gin_sel_n = bgin_n[lvl_sel];

  bgn_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mst_req   (mst_req),
    .mst_done  (mst_done),
    .gin_sel_n (gin_sel_n),
    .req_act   (req_act),
    .own       (bus_own),
    .blk       (blk)
  );

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    logic hit;
    assign hit          = (lvl_sel == LVL_W'(i));
    assign bus_req_n[i] = ~(req_act && hit);

    bgn_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .gin_n  (bgin_n[i]),
      .blk_i  (blk && hit),
      .gout_n (bgout_n[i])
    );
  end

  // R2
  single_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~bus_req_n) <= 1) && (bus_req_n[lvl_sel] || 1'b1) &&
    ((&bus_req_n) || !bus_req_n[lvl_sel]));

  // R6
  own_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own |-> (&bus_req_n));
endmodule

// File: tb/bgchain_node_tb.sv
module bgchain_node_tb;
  localparam int NL = 4;
  localparam int NC = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 0;

  // directed DUT
  logic          rst_n;
  logic [1:0]    lvl_sel;
  logic          mst_req, mst_done;
  logic          bus_own;
  logic [NL-1:0] bgin_n, bgout_n, bus_req_n;

  bgchain_node u_dut (
    .clk(clk), .rst_n(rst_n), .lvl_sel(lvl_sel), .mst_req(mst_req),
    .mst_done(mst_done), .bus_own(bus_own), .bgin_n(bgin_n),
    .bgout_n(bgout_n), .bus_req_n(bus_req_n)
  );

  // chain of nodes
  logic [NL-1:0] ch_bg [NC+1];
  logic [NL-1:0] ch_req [NC];
  logic [NC-1:0] ch_own, ch_mreq, ch_mdone;
  logic [NL-1:0] arb_bg_n;
  assign ch_bg[0] = arb_bg_n;

  function automatic logic [1:0] chain_lvl(int k);
    return (k % 2 == 0) ? 2'd1 : 2'd3;
  endfunction

  for (genvar k = 0; k < NC; k++) begin : g_ch
    bgchain_node u_chain (
      .clk(clk), .rst_n(rst_n), .lvl_sel(chain_lvl(k)), .mst_req(ch_mreq[k]),
      .mst_done(ch_mdone[k]), .bus_own(ch_own[k]), .bgin_n(ch_bg[k]),
      .bgout_n(ch_bg[k+1]), .bus_req_n(ch_req[k])
    );
  end

  function automatic logic [NL-1:0] exp_req(logic [1:0] l);
    return ~(NL'(1) << l);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    summary();
  end

  initial begin
    int hold [NC];
    int wait_c [NC];
    int sess [NC];
    int arb_st, rr, tmo;
    logic [NL-1:0] line;
    logic [NL-1:0] pat;

    void'($urandom(32'h5eed1234));
    rst_n = 0; lvl_sel = 2'd2; mst_req = 0; mst_done = 0; bgin_n = '1;
    arb_bg_n = '1; ch_mreq = '0; ch_mdone = '0;
    repeat (3) step();
    chk(bus_req_n == '1 && bgout_n == '1 && bus_own == 1'b0, "R1 reset",
        {bus_own, bgout_n, bus_req_n}, {1'b0, 8'hff});
    rst_n = 1;

    // R3 idle pass-through, random patterns
    for (int n = 0; n < 8; n++) begin
      pat = NL'($urandom);
      bgin_n = pat;
      step();
      chk(bgout_n == pat, "R3 idle copy", bgout_n, pat);
      chk(bus_req_n == '1, "R4 no request without mst_req", bus_req_n, 4'hf);
    end

    // R4/R8 grant in flight on own level while master asks
    bgin_n = 4'b1011; mst_req = 1;
    step();
    chk(bus_req_n == '1, "R4 held off while grant-in low", bus_req_n, 4'hf);
    chk(bgout_n == 4'b1011, "R3 in-flight grant kept", bgout_n, 4'b1011);
    step();
    chk(bus_req_n == '1, "R4 still held off", bus_req_n, 4'hf);
    bgin_n = 4'b1111;
    step();
    chk(bus_req_n == exp_req(2), "R2 R4 request on level 2", bus_req_n, exp_req(2));
    chk(bus_own == 0, "R6 not yet owner", bus_own, 0);

    // R5 + R3 other levels while requesting
    for (int n = 0; n < 6; n++) begin
      pat = NL'($urandom) | 4'b0100;
      bgin_n = pat;
      step();
      chk(bgout_n == (pat | 4'b0100), "R3 R5 other levels copy", bgout_n, pat | 4'b0100);
    end

    // R9 done while requesting
    bgin_n = 4'b1111; mst_done = 1;
    step();
    mst_done = 0;
    chk(bus_req_n == exp_req(2) && !bus_own, "R9 done ignored in request",
        {bus_own, bus_req_n}, {1'b0, exp_req(2)});

    // R6 grant
    bgin_n = 4'b1011;
    step();
    chk(bus_own == 1, "R6 own after grant", bus_own, 1);
    chk(bus_req_n == '1, "R6 request released", bus_req_n, 4'hf);
    chk(bgout_n[2] == 1, "R5 grant absorbed", bgout_n, 4'b1111);
    repeat (3) step();
    chk(bus_own == 1, "R6 own held", bus_own, 1);

    // R7 done
    mst_done = 1; mst_req = 0;
    step();
    mst_done = 0;
    chk(bus_own == 0, "R7 release on done", bus_own, 0);
    mst_req = 1;
    for (int n = 0; n < 3; n++) begin
      step();
      chk(bus_req_n == '1, "R8 no request in drain", bus_req_n, 4'hf);
      chk(bgout_n[2] == 1, "R8 grant-out blocked in drain", bgout_n, 4'b1111);
    end
    bgin_n = 4'b1111;
    step();
    chk(bus_req_n == '1, "R8 first edge after negation", bus_req_n, 4'hf);
    step();
    chk(bus_req_n == exp_req(2), "R8 request after negation", bus_req_n, exp_req(2));

    // R9 done in idle
    rst_n = 0; step(); rst_n = 1; mst_req = 0;
    bgin_n = 4'b0101;
    step();
    mst_done = 1;
    step();
    mst_done = 0;
    chk(bus_req_n == '1 && !bus_own && bgout_n == 4'b0101, "R9 done ignored in idle",
        {bus_own, bgout_n, bus_req_n}, {1'b0, 4'b0101, 4'hf});

    // R2 level 0 after re-reset
    rst_n = 0; lvl_sel = 2'd0; bgin_n = '1;
    step();
    rst_n = 1; mst_req = 1;
    step();
    chk(bus_req_n == exp_req(0), "R2 request on level 0", bus_req_n, exp_req(0));
    mst_req = 0;

    // chain random run
    for (int k = 0; k < NC; k++) begin hold[k] = 0; wait_c[k] = 0; sess[k] = 0; end
    arb_st = 0; rr = 0; tmo = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      step();
      chk($countones(ch_own) <= 1, "R6 single owner", ch_own, 0);
      line = '1;
      for (int k = 0; k < NC; k++) line &= ch_req[k];
      for (int k = 0; k < NC; k++) begin
        if (ch_own[k] && !ch_mreq[k]) chk(0, "R6 owner did not request", k, 0);
        ch_mdone[k] = 0;
        if (ch_own[k]) begin
          wait_c[k] = 0;
          if (hold[k] == 0) begin
            ch_mdone[k] = 1; ch_mreq[k] = 0; sess[k]++;
          end else hold[k]--;
        end else if (ch_mreq[k]) begin
          wait_c[k]++;
          if (wait_c[k] == 1500) chk(0, "R4 R6 request starved", k, 0);
        end else if ($urandom % 8 == 0 && cyc < 3800) begin
          ch_mreq[k] = 1; hold[k] = $urandom % 4; wait_c[k] = 0;
        end
      end
      case (arb_st)
        0: if (ch_own == 0) begin
             for (int j = 1; j <= NL; j++) begin
               int l;
               l = (rr + j) % NL;
               if (arb_st == 0 && !line[l]) begin
                 arb_bg_n = ~(NL'(1) << l); rr = l; arb_st = 1; tmo = 0;
               end
             end
           end
        1: if (ch_own != 0) begin
             arb_bg_n = '1; arb_st = 2;
           end else begin
             tmo++;
             if (tmo > 64) begin arb_bg_n = '1; arb_st = 0; end
           end
        default: if (ch_own == 0) arb_st = 0;
      endcase
    end
    for (int k = 0; k < NC; k++)
      chk(sess[k] > 0, "R6 every chained node served", sess[k], 1);
    summary();
  end
endmodule